// File: doc/BRIEF.md
# Differential Gray Pixel Encoder

This block sits between an image-sensor ADC and the parallel pixel output. On every clock it takes one 12-bit sample. A line-start marker (the optical-black pulse) resets its place in the line. In differential mode it sends a few reference pixels unchanged at a chosen place after the marker. Every later pixel in the line is sent as the modulo-4096 difference from an earlier sample. That earlier sample is either two clocks back, so that colour-filter neighbours of the same colour are compared, or one clock back. The word can then be converted to Gray code, over all twelve bits or over the low ten only. When the picture brightness changes slowly, this keeps the number of output bits that toggle together small.

The position of each pixel in the line is tracked by a four-state controller. The states are:
- `LN_IDLE`: no marker seen since reset; samples pass raw.
- `LN_LEAD`: pixels after the marker that come before the references; they pass raw.
- `LN_REF`: reference pixels; they pass raw.
- `LN_DIFF`: the rest of the line; these samples are differenced when differential mode is on.

The transitions are:
- `mark_seen`: any state goes to `LN_LEAD` when a marker edge is detected.
- `reach_ref`: `LN_LEAD` goes to `LN_REF` when the next pixel is the first reference.
- `refs_done`: `LN_REF` goes to `LN_DIFF` after the last reference.
- `hold`: every other case stays in the same state.

Top module: `diff_gray_encoder`

## Requirements
- R1: While rst_n is low, out_valid and out_code are 0. out_valid goes to 1 on the second rising edge after rst_n is released, and it stays at 1 from then on.
- R2: The word derived from the pix_in value sampled at rising edge n appears on out_code after rising edge n+1.
- R3: With cfg_diff=0 and cfg_gray=0, out_code equals the sampled pix_in.
- R4: With cfg_mark_neg=0, mark_in is sampled on rising edges, and pixel 1 of a line is the sample taken two rising edges after the first rising edge that saw mark_in high. With cfg_mark_neg=1, mark_in is sampled on falling edges, and pixel 1 is the sample taken on the second rising edge after the first falling edge that saw mark_in high. Only a low-to-high change of the selected sample counts.
- R5: The first reference pixel is pixel 3+cfg_pos, where cfg_pos is read as an unsigned 2-bit number. With cfg_one_ref=0 there are two reference pixels, the first and the next one. With cfg_one_ref=1 there is one. Reference pixels are sent unmodified.
- R6: Pixels after the marker that come before the first reference, and all samples before the first marker after reset, are sent unmodified.
- R7: With cfg_diff=1, every pixel after the references, up to the next marker, is sent as (current sample − earlier sample) mod 4096. The earlier sample is 2 pixels back when cfg_one_ref=0 and 1 pixel back when cfg_one_ref=1.
- R8: With cfg_gray=1 and cfg_gray10=0, the word is converted so that output bit i equals word bit i XOR word bit i+1, and the top bit passes unchanged.
- R9: With cfg_gray=1 and cfg_gray10=1, word bits 11:10 pass unchanged and only bits 9:0 are Gray-converted, with bit 9 as their top bit.
- R10: A new marker during a line re-arms the count. Pixel numbering, references and differencing restart from the new marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | 12 | ADC sample |
| mark_in | input | 1 | Line-start marker, active high |
| cfg_gray | input | 1 | 1: Gray output, 0: binary |
| cfg_diff | input | 1 | 1: differential coding |
| cfg_gray10 | input | 1 | 1: Gray over the low 10 bits only |
| cfg_one_ref | input | 1 | 1: one reference pixel and 1-pixel lag |
| cfg_pos | input | 2 | Reference position code; the first reference is pixel 3+cfg_pos |
| cfg_mark_neg | input | 1 | 1: sample mark_in on falling edges |
| out_code | output | 12 | Encoded output word |
| out_valid | output | 1 | Output word valid |

## Verification
A wrong line state or wrong pixel counter shows up at the ports as references that start one pixel early or late. It also shows up as raw words where differences belong, or the other way round. Either error is visible on out_code two clocks after the affected sample. A bad history register gives difference values that are wrong from the first differenced pixel of the line onward. Because that pixel lies only a few clocks after the marker, every line with differencing turned on reveals the error almost at once.

// File: rtl/dg_pkg.sv
package dg_pkg;

    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_LEAD = 2'd1,
        LN_REF  = 2'd2,
        LN_DIFF = 2'd3
    } line_state_e;

endpackage

// File: rtl/dg_mark_sense.sv
module dg_mark_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_in,
    input  logic sel_neg_i,
    output logic edge_o
);

    logic rise_q;
    logic fall_q;
    logic prev_q;
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= 1'b0;
        else        rise_q <= mark_in;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= mark_in;
    end

    assign seen = sel_neg_i ? fall_q : rise_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= seen;
    end

    assign edge_o = seen & ~prev_q;

endmodule

// File: rtl/dg_line_fsm.sv
module dg_line_fsm
    import dg_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int POS_W    = 2,
    parameter int POS_BASE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             one_ref_i,
    output logic             diff_slot_o
);

    line_state_e      state_q;
    line_state_e      state_d;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_d;
    logic [IDX_W-1:0] first_ref;
    logic [IDX_W-1:0] last_ref;
    logic [IDX_W-1:0] idx_inc;

    assign first_ref = IDX_W'(POS_BASE) + IDX_W'(pos_i);
    assign last_ref  = first_ref + (one_ref_i ? IDX_W'(0) : IDX_W'(1));
    assign idx_inc   = idx_q + IDX_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (edge_i) begin
            state_d = LN_LEAD;
            idx_d   = IDX_W'(1);
        end else begin
            unique case (state_q)
                LN_IDLE: ;
                LN_LEAD: begin
                    idx_d = idx_inc;
                    if (idx_inc == first_ref) state_d = LN_REF;
                end
                LN_REF: begin
                    idx_d = idx_inc;
                    if (idx_q == last_ref) state_d = LN_DIFF;
                end
                LN_DIFF: ;
                default: state_d = LN_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            LN_DIFF: diff_slot_o = 1'b1;
            default: diff_slot_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dg_diff_stage.sv
module dg_diff_stage #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pix_i,
    input  logic         diff_en_i,
    input  logic         one_ref_i,
    output logic [W-1:0] val_o,
    output logic         vld_o
);

    logic [W-1:0] hist1_q;
    logic [W-1:0] hist2_q;
    logic [W-1:0] base;
    logic [W-1:0] delta;

    assign base  = one_ref_i ? hist1_q : hist2_q;
    assign delta = pix_i - base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist1_q <= '0;
            hist2_q <= '0;
            val_o   <= '0;
            vld_o   <= 1'b0;
        end else begin
            hist1_q <= pix_i;
            hist2_q <= hist1_q;
            val_o   <= diff_en_i ? delta : pix_i;
            vld_o   <= 1'b1;
        end
    end

endmodule

// File: rtl/dg_gray_stage.sv
module dg_gray_stage #(
    parameter int W    = 12,
    parameter int LO_W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] val_i,
    input  logic         vld_i,
    input  logic         gray_i,
    input  logic         narrow_i,
    output logic [W-1:0] code_o,
    output logic         vld_o
);

    logic [W-1:0] g_full;
    logic [W-1:0] g_part;
    logic [W-1:0] pick;

    assign g_full = val_i ^ (val_i >> 1);

    if (LO_W < W) begin : g_narrow
        logic [LO_W-1:0] lo;
        assign lo     = val_i[LO_W-1:0];
        assign g_part = {val_i[W-1:LO_W], lo ^ (lo >> 1)};
    end else begin : g_same
        assign g_part = g_full;
    end

    assign pick = !gray_i ? val_i : (narrow_i ? g_part : g_full);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            code_o <= pick;
            vld_o  <= vld_i;
        end
    end

endmodule

// File: rtl/diff_gray_encoder.sv
module diff_gray_encoder #(
    parameter int PIX_W     = 12,
    parameter int GRAY_LO_W = 10,
    parameter int IDX_W     = 4,
    parameter int POS_W     = 2,
    parameter int POS_BASE  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             mark_in,
    input  logic             cfg_gray,
    input  logic             cfg_diff,
    input  logic             cfg_gray10,
    input  logic             cfg_one_ref,
    input  logic [POS_W-1:0] cfg_pos,
    input  logic             cfg_mark_neg,
    output logic [PIX_W-1:0] out_code,
    output logic             out_valid
);

    logic             mark_edge;
    logic             diff_slot;
    logic [PIX_W-1:0] mid_val;
    logic             mid_vld;

    dg_mark_sense u_mark (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark_in   (mark_in),
        .sel_neg_i (cfg_mark_neg),
        .edge_o    (mark_edge)
    );

    dg_line_fsm #(
        .IDX_W    (IDX_W),
        .POS_W    (POS_W),
        .POS_BASE (POS_BASE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_i      (mark_edge),
        .pos_i       (cfg_pos),
        .one_ref_i   (cfg_one_ref),
        .diff_slot_o (diff_slot)
    );

    dg_diff_stage #(
        .W (PIX_W)
    ) u_diff (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_i     (pix_in),
        .diff_en_i (cfg_diff & diff_slot),
        .one_ref_i (cfg_one_ref),
        .val_o     (mid_val),
        .vld_o     (mid_vld)
    );

    dg_gray_stage #(
        .W    (PIX_W),
        .LO_W (GRAY_LO_W)
    ) u_gray (
        .clk      (clk),
        .rst_n    (rst_n),
        .val_i    (mid_val),
        .vld_i    (mid_vld),
        .gray_i   (cfg_gray),
        .narrow_i (cfg_gray10),
        .code_o   (out_code),
        .vld_o    (out_valid)
    );

endmodule

// File: rtl/diff_gray_encoder_chk.sv
module diff_gray_encoder_chk #(
    parameter int W    = 12,
    parameter int LO_W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] pix_in,
    input logic         cfg_gray,
    input logic         cfg_diff,
    input logic         cfg_gray10,
    input logic [W-1:0] out_code,
    input logic         out_valid
);

    function automatic logic [W-1:0] from_gray(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!out_valid && out_code == '0)
                else $error("R1 output active during reset");
        end
    end

    a_r1_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

    a_r3_plain_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !$past(cfg_diff, 2) && !$past(cfg_gray))
        |-> out_code == $past(pix_in, 2));

    a_r8_gray_decodes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !$past(cfg_diff, 2) && $past(cfg_gray)
         && !$past(cfg_gray10))
        |-> from_gray(out_code) == $past(pix_in, 2));

    a_r9_upper_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !$past(cfg_diff, 2) && $past(cfg_gray)
         && $past(cfg_gray10))
        |-> out_code[W-1:LO_W] == $past(pix_in[W-1:LO_W], 2));

endmodule

bind diff_gray_encoder diff_gray_encoder_chk #(
    .W    (PIX_W),
    .LO_W (GRAY_LO_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_in     (pix_in),
    .cfg_gray   (cfg_gray),
    .cfg_diff   (cfg_diff),
    .cfg_gray10 (cfg_gray10),
    .out_code   (out_code),
    .out_valid  (out_valid)
);

// File: tb/diff_gray_encoder_tb_top.sv
`timescale 1ns/1ps
module diff_gray_encoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pix_in = '0;
    logic        mark_in = 1'b0;
    logic        cfg_gray = 1'b0;
    logic        cfg_diff = 1'b0;
    logic        cfg_gray10 = 1'b0;
    logic        cfg_one_ref = 1'b0;
    logic [1:0]  cfg_pos = '0;
    logic        cfg_mark_neg = 1'b0;
    logic [11:0] out_code;
    logic        out_valid;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    diff_gray_encoder dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_in       (pix_in),
        .mark_in      (mark_in),
        .cfg_gray     (cfg_gray),
        .cfg_diff     (cfg_diff),
        .cfg_gray10   (cfg_gray10),
        .cfg_one_ref  (cfg_one_ref),
        .cfg_pos      (cfg_pos),
        .cfg_mark_neg (cfg_mark_neg),
        .out_code     (out_code),
        .out_valid    (out_valid)
    );

    // vector bits: [6] marker on falling edge, [5:4] position, [3] one ref,
    // [2] gray over 10 bits, [1] gray, [0] differential
    localparam int NV = 8;
    localparam logic [6:0] VEC [NV] = '{
        7'b0_00_0_0_0_0,
        7'b0_00_0_0_0_1,
        7'b0_01_1_0_0_1,
        7'b1_10_0_0_1_1,
        7'b0_11_1_1_1_1,
        7'b1_00_0_0_1_0,
        7'b0_00_0_1_1_0,
        7'b1_11_0_0_0_1
    };

    function automatic logic [11:0] pixv(input int c, input int seed);
        return 12'((c * 613 + seed * 977 + ((c % 2 == 1) ? 2900 : 0)) % 4096);
    endfunction

    // kind: 0 before first marker, 1 leading, 2 reference, 3 differenced slot
    function automatic int kind_of(input int s, input logic [6:0] cf,
                                   input int mk1, input int mk2);
        int first;
        int k;
        int start;
        int nref;
        first = -1;
        if (mk1 >= 0 && mk1 + 2 - int'(cf[6]) <= s) first = mk1 + 2 - int'(cf[6]);
        if (mk2 >= 0 && mk2 + 2 - int'(cf[6]) <= s) first = mk2 + 2 - int'(cf[6]);
        if (first < 0) return 0;
        k     = s - first + 1;
        start = 3 + int'(cf[5:4]);
        nref  = cf[3] ? 1 : 2;
        if (k < start) return 1;
        if (k < start + nref) return 2;
        return 3;
    endfunction

    function automatic logic [11:0] gray_bits(input logic [11:0] v, input int top);
        logic [11:0] g;
        g = v;
        for (int i = 0; i < top - 1; i++) g[i] = v[i] ^ v[i+1];
        return g;
    endfunction

    function automatic logic [11:0] model(input int s, input logic [6:0] cf,
                                          input int mk1, input int mk2, input int seed);
        logic [11:0] v;
        int lag;
        lag = cf[3] ? 1 : 2;
        v = pixv(s, seed);
        if (cf[0] && kind_of(s, cf, mk1, mk2) == 3) v = pixv(s, seed) - pixv(s - lag, seed);
        if (cf[1]) v = gray_bits(v, cf[2] ? 10 : 12);
        return v;
    endfunction

    function automatic string tag_of(input int kind, input logic [6:0] cf);
        string t;
        case (kind)
            1: t = "R2 R4 R6";
            2: t = "R2 R4 R5";
            3: t = cf[0] ? "R2 R7" : "R2 R3";
            default: t = cf[0] ? "R2 R6" : "R2 R3";
        endcase
        if (cf[1]) t = {t, cf[2] ? " R9" : " R8"};
        return t;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run(input logic [6:0] cf, input int mk1, input int mk2,
                       input int n, input int seed, input string pre);
        logic [11:0] e;
        rst_n = 1'b0;
        mark_in = 1'b0;
        pix_in = '0;
        {cfg_mark_neg, cfg_pos, cfg_one_ref, cfg_gray10, cfg_gray, cfg_diff} = cf;
        repeat (3) @(posedge clk);
        #3;
        check(out_valid == 1'b0, "R1 valid in reset", {11'd0, out_valid}, 12'd0);
        check(out_code == '0, "R1 code in reset", out_code, 12'd0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int c = 0; c < n; c++) begin
            @(posedge clk);
            #1;
            pix_in  = pixv(c, seed);
            mark_in = (c >= mk1 && c < mk1 + 3) || (mk2 >= 0 && c >= mk2 && c < mk2 + 3);
            #2;
            if (c == 0)
                check(out_valid == 1'b0, "R1 valid one edge after release",
                      {11'd0, out_valid}, 12'd0);
            else if (c == 1)
                check(out_valid == 1'b1, "R1 valid two edges after release",
                      {11'd0, out_valid}, 12'd1);
            if (c >= 2) begin
                e = model(c - 2, cf, mk1, mk2, seed);
                check(out_code == e, {pre, tag_of(kind_of(c - 2, cf, mk1, mk2), cf)},
                      out_code, e);
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int v = 0; v < NV; v++) run(VEC[v], 3, -1, 24, v, "");
        // R10: second marker in mid-line re-arms numbering and differencing
        run(7'b0_00_0_0_0_1, 3, 13, 30, 11, "R10 ");
        run(7'b1_01_1_0_1_1, 2, 12, 28, 12, "R10 ");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule